// File: doc/BRIEF.md
# Bandwidth-Limited In-Order Commit Controller

This block sits at the retire end of a multithreaded out-of-order core. Each cycle a thread selector grants one thread, and the reorder buffer of that thread presents its oldest `LOOK` entries as head slots, each carrying a descriptor. The descriptor holds status flags, a sequence number, a PC and a next PC. The controller scans the slots from oldest to youngest. It retires squashed entries without charging them to the bandwidth budget. It commits executed, fault-free entries until `W` have committed. It stops at the first entry that is absent or not ready, or that needs special handling.

Special handling covers several cases. An un-executed serializing entry (non-speculative, store-conditional, memory barrier or write barrier) asks the execute stage to run it. An un-executed load is sent back as an uncached access. A faulting entry raises a trap request and parks its thread. Serializing and faulting entries act only when they are the first commit candidate of the cycle and the memory stage reports no pending stores. The block keeps a PC and next PC for each thread, statistics counters, and a one-cycle-delayed broadcast of free reorder-buffer entries.

The head slots form a stream interface. `head_vld[i]` offers slot i and `head_pop[i]` is its ready/acknowledge. A slot is consumed only when it is offered, and the popped slots always form a contiguous run starting at slot 0. Slots that are not popped must be presented again in a later cycle. `head_pop` depends combinationally on the slots, the grant and `stores_pending` in the same cycle.

Top module: `commit_ctrl`

## Requirements
- R1: Each head slot is a package `head_t` value at `head_bus[i*HW +: HW]`, with slot 0 the oldest. The scan pops a contiguous run from slot 0 and commits at most `W` non-squashed entries per cycle. The scan stops at the first slot that is not offered or whose ready flag is clear.
- R2: When `grant_vld` is low, or the granted thread has its trap-pending bit set, nothing is popped and no done or request output is raised.
- R3: A squashed slot is popped without counting toward `W`, and `stat_sq` grows by one for each such slot, one cycle later.
- R4: An un-executed slot flagged non-speculative, store-conditional, memory barrier or write barrier stops the scan. If no commit precedes it in the cycle and `stores_pending` is low, it raises `nspec_req` with its sequence number on `req_seq`. Otherwise it waits with no request.
- R5: An un-executed load slot stops the scan and raises `uncached_req` with its sequence number on `req_seq`, regardless of its position or of pending stores.
- R6: A faulting executed slot stops the scan. If no commit precedes it and `stores_pending` is low, it raises `trap_req` with `trap_tid`, and the thread's bit in `trap_pending` is set from the next cycle until a `trap_clear` pulse for that thread.
- R7: While at least one entry commits, `done_vld` is high and `done_seq` carries the sequence number of the youngest committed slot, combinationally.
- R8: After a cycle with a commit, the thread's PC equals the last committed slot's next PC, and its next PC is that value plus `ISZ`. If the scan stops on a slot that is ready and not squashed, the thread's PC and next PC take that slot's PC and next PC.
- R9: Slots flagged nop or instruction-prefetch count toward `W` but do not increase `stat_inst`. Other committed slots each add one.
- R10: `stat_last` holds the number committed in the previous cycle, and `stat_full` counts the cycles in which exactly `W` committed.
- R11: One cycle after any pop, `fb_vld` is high, `fb_tid` names the thread, and `fb_free` equals `DEPTH - (rob_used - popped)`. `fb_empty` is high when the pops drained the buffer. `fb_vld` is low after a cycle with no pop.
- R12: An un-executed slot with none of the serializing or load flags stops the scan and sets `err_unknown`, which stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| grant_vld | input | 1 | a thread is granted this cycle |
| grant_tid | input | TIDW | granted thread |
| head_vld | input | LOOK | head slot offered (stream valid) |
| head_bus | input | LOOK*HW | head slot descriptors, slot 0 oldest |
| head_pop | output | LOOK | slot consumed (stream ready) |
| stores_pending | input | 1 | memory stage still holds stores to write back |
| rob_used | input | UW | occupied entries of the granted thread before this cycle's pops |
| trap_clear | input | NT | per-thread clear of trap-pending |
| done_vld | output | 1 | at least one commit this cycle |
| done_tid | output | TIDW | thread of the commits |
| done_seq | output | SEQ_W | sequence number of youngest commit |
| nspec_req | output | 1 | execute-at-head request |
| uncached_req | output | 1 | uncached load request |
| req_seq | output | SEQ_W | sequence number for either request |
| trap_req | output | 1 | trap request |
| trap_tid | output | TIDW | thread that trapped |
| trap_pending | output | NT | per-thread trap-pending status |
| err_unknown | output | 1 | sticky unknown un-executed entry |
| thread_pc | output | NT*PC_W | per-thread PC |
| thread_npc | output | NT*PC_W | per-thread next PC |
| fb_vld | output | 1 | free-entry broadcast valid |
| fb_tid | output | TIDW | broadcast thread |
| fb_free | output | UW | free entries |
| fb_empty | output | 1 | buffer drained |
| stat_last | output | CW | commits in the previous cycle |
| stat_full | output | SW | cycles at full width |
| stat_sq | output | SW | squashed entries skipped |
| stat_inst | output | SW | architectural instructions committed |

## Verification
The properties assume that `grant_tid` names an existing thread and that the head slots and `stores_pending` are stable between clock edges. They also assume that `rob_used` is never smaller than the number of slots offered. The bench drives every input one time unit after a rising edge and holds it for the full cycle. It keeps `rob_used` at or above the offered count, and it grants only thread indices below `NT`. Fault and unknown-entry cases run in directed steps after the vector table, so their sticky effects do not disturb the table's expectations.

// File: rtl/commit_pkg.sv
package commit_pkg;
  localparam int SEQ_W = 16;
  localparam int PC_W  = 32;

  typedef struct packed {
    logic             ready;
    logic             executed;
    logic             squashed;
    logic             nonspec;
    logic             stcond;
    logic             membar;
    logic             wrbar;
    logic             load;
    logic             store;
    logic             fault;
    logic             nop;
    logic             ipref;
    logic [SEQ_W-1:0] seq;
    logic [PC_W-1:0]  pc;
    logic [PC_W-1:0]  npc;
  } head_t;

  localparam int HEAD_W = $bits(head_t);

  typedef struct packed {
    logic halt;
    logic sq;
    logic spec;
    logic unld;
    logic bad;
    logic flt;
    logic ok;
    logic arch;
  } slot_cls_t;
endpackage

// File: rtl/commit_slot_cls.sv
module commit_slot_cls
  import commit_pkg::*;
(
  input  logic      vld,
  input  head_t     head,
  output slot_cls_t cls
);
  logic live, unex, special, unused_bits;

  assign live    = vld && head.ready;
  assign unex    = live && !head.squashed && !head.executed;
  assign special = head.nonspec | head.stcond | head.membar | head.wrbar;

  always_comb begin
    cls.halt = !live;
    cls.sq   = live && head.squashed;
    cls.spec = unex && special;
    cls.unld = unex && !special && head.load;
    cls.bad  = unex && !special && !head.load;
    cls.flt  = live && !head.squashed && head.executed && head.fault;
    cls.ok   = live && !head.squashed && head.executed && !head.fault;
    cls.arch = cls.ok && !head.nop && !head.ipref;
  end

  assign unused_bits = ^{head.seq, head.pc, head.npc, head.store};
endmodule

// File: rtl/commit_scan.sv
module commit_scan
  import commit_pkg::*;
#(
  parameter int W    = 2,
  parameter int LOOK = 4,
  parameter int ISZ  = 4,
  localparam int CW  = $clog2(LOOK + 1)
) (
  input  logic             enable,
  input  logic             stores_pending,
  input  slot_cls_t        cls   [LOOK],
  input  head_t            heads [LOOK],
  output logic [LOOK-1:0]  pop,
  output logic [CW-1:0]    ncommit,
  output logic [CW-1:0]    nsq,
  output logic [CW-1:0]    ninst,
  output logic             done_vld,
  output logic [SEQ_W-1:0] done_seq,
  output logic             nspec,
  output logic             unc,
  output logic             trap,
  output logic             bad,
  output logic [SEQ_W-1:0] req_seq,
  output logic             pc_upd,
  output logic [PC_W-1:0]  pc_new,
  output logic [PC_W-1:0]  npc_new
);
  always_comb begin : scan
    logic          go;
    logic [CW-1:0] cnt;
    pop      = '0;
    nsq      = '0;
    ninst    = '0;
    done_vld = 1'b0;
    done_seq = '0;
    nspec    = 1'b0;
    unc      = 1'b0;
    trap     = 1'b0;
    bad      = 1'b0;
    req_seq  = '0;
    pc_upd   = 1'b0;
    pc_new   = '0;
    npc_new  = '0;
    go       = enable;
    cnt      = '0;
    for (int i = 0; i < LOOK; i++) begin
      if (go) begin
        if (cnt == CW'(W) || cls[i].halt) begin
          go = 1'b0;
        end else if (cls[i].sq) begin
          pop[i] = 1'b1;
          nsq    = nsq + CW'(1);
        end else if (cls[i].ok) begin
          pop[i]   = 1'b1;
          cnt      = cnt + CW'(1);
          if (cls[i].arch) ninst = ninst + CW'(1);
          done_vld = 1'b1;
          done_seq = heads[i].seq;
          pc_upd   = 1'b1;
          pc_new   = heads[i].npc;
          npc_new  = heads[i].npc + PC_W'(ISZ);
        end else begin
          go      = 1'b0;
          pc_upd  = 1'b1;
          pc_new  = heads[i].pc;
          npc_new = heads[i].npc;
          req_seq = heads[i].seq;
          if (cls[i].unld) begin
            unc = 1'b1;
          end else if (cls[i].bad) begin
            bad = 1'b1;
          end else if (cnt == '0 && !stores_pending) begin
            nspec = cls[i].spec;
            trap  = cls[i].flt;
          end
        end
      end
    end
    ncommit = cnt;
  end
endmodule

// File: rtl/commit_thread_ctx.sv
module commit_thread_ctx
  import commit_pkg::*;
#(
  parameter int NT   = 2,
  parameter int TIDW = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               upd,
  input  logic [TIDW-1:0]    upd_tid,
  input  logic [PC_W-1:0]    pc_new,
  input  logic [PC_W-1:0]    npc_new,
  input  logic               trap_set,
  input  logic [NT-1:0]      trap_clear,
  output logic [NT*PC_W-1:0] pc_flat,
  output logic [NT*PC_W-1:0] npc_flat,
  output logic [NT-1:0]      pend
);
  for (genvar t = 0; t < NT; t++) begin : g_thr
    logic [PC_W-1:0] pc_q, npc_q;
    logic            hit;
    assign hit = (upd_tid == TIDW'(t));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pc_q    <= '0;
        npc_q   <= '0;
        pend[t] <= 1'b0;
      end else begin
        if (upd && hit) begin
          pc_q  <= pc_new;
          npc_q <= npc_new;
        end
        pend[t] <= (pend[t] && !trap_clear[t]) || (trap_set && hit);
      end
    end

    assign pc_flat[t*PC_W +: PC_W]  = pc_q;
    assign npc_flat[t*PC_W +: PC_W] = npc_q;
  end
endmodule

// File: rtl/commit_stats.sv
module commit_stats #(
  parameter int W     = 2,
  parameter int LOOK  = 4,
  parameter int DEPTH = 16,
  parameter int SW    = 16,
  parameter int TIDW  = 1,
  localparam int CW   = $clog2(LOOK + 1),
  localparam int UW   = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [LOOK-1:0] pop,
  input  logic [CW-1:0]   ncommit,
  input  logic [CW-1:0]   nsq,
  input  logic [CW-1:0]   ninst,
  input  logic            bad,
  input  logic [TIDW-1:0] tid,
  input  logic [UW-1:0]   rob_used,
  output logic            err_unknown,
  output logic            fb_vld,
  output logic [TIDW-1:0] fb_tid,
  output logic [UW-1:0]   fb_free,
  output logic            fb_empty,
  output logic [CW-1:0]   stat_last,
  output logic [SW-1:0]   stat_full,
  output logic [SW-1:0]   stat_sq,
  output logic [SW-1:0]   stat_inst
);
  logic [UW-1:0] popped, remain;

  assign popped = UW'($countones(pop));
  assign remain = rob_used - popped;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_unknown <= 1'b0;
      fb_vld      <= 1'b0;
      fb_tid      <= '0;
      fb_free     <= '0;
      fb_empty    <= 1'b0;
      stat_last   <= '0;
      stat_full   <= '0;
      stat_sq     <= '0;
      stat_inst   <= '0;
    end else begin
      err_unknown <= err_unknown || bad;
      fb_vld      <= |pop;
      if (|pop) begin
        fb_tid   <= tid;
        fb_free  <= UW'(DEPTH) - remain;
        fb_empty <= (remain == '0);
      end
      stat_last <= ncommit;
      if (ncommit == CW'(W)) stat_full <= stat_full + SW'(1);
      stat_sq   <= stat_sq + SW'(nsq);
      stat_inst <= stat_inst + SW'(ninst);
    end
  end
endmodule

// File: rtl/commit_ctrl.sv
module commit_ctrl
  import commit_pkg::*;
#(
  parameter int NT    = 2,
  parameter int W     = 2,
  parameter int LOOK  = 4,
  parameter int DEPTH = 16,
  parameter int ISZ   = 4,
  parameter int SW    = 16,
  localparam int TIDW = (NT > 1) ? $clog2(NT) : 1,
  localparam int HW   = HEAD_W,
  localparam int CW   = $clog2(LOOK + 1),
  localparam int UW   = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               grant_vld,
  input  logic [TIDW-1:0]    grant_tid,
  input  logic [LOOK-1:0]    head_vld,
  input  logic [LOOK*HW-1:0] head_bus,
  output logic [LOOK-1:0]    head_pop,
  input  logic               stores_pending,
  input  logic [UW-1:0]      rob_used,
  input  logic [NT-1:0]      trap_clear,
  output logic               done_vld,
  output logic [TIDW-1:0]    done_tid,
  output logic [SEQ_W-1:0]   done_seq,
  output logic               nspec_req,
  output logic               uncached_req,
  output logic [SEQ_W-1:0]   req_seq,
  output logic               trap_req,
  output logic [TIDW-1:0]    trap_tid,
  output logic [NT-1:0]      trap_pending,
  output logic               err_unknown,
  output logic [NT*PC_W-1:0] thread_pc,
  output logic [NT*PC_W-1:0] thread_npc,
  output logic               fb_vld,
  output logic [TIDW-1:0]    fb_tid,
  output logic [UW-1:0]      fb_free,
  output logic               fb_empty,
  output logic [CW-1:0]      stat_last,
  output logic [SW-1:0]      stat_full,
  output logic [SW-1:0]      stat_sq,
  output logic [SW-1:0]      stat_inst
);
  head_t           heads [LOOK];
  slot_cls_t       cls   [LOOK];
  logic            enable, bad, pc_upd;
  logic [CW-1:0]   ncommit, nsq, ninst;
  logic [PC_W-1:0] pc_new, npc_new;

  assign enable = grant_vld && (int'(grant_tid) < NT) && !trap_pending[grant_tid];

  for (genvar g = 0; g < LOOK; g++) begin : g_slot
    assign heads[g] = head_t'(head_bus[g*HW +: HW]);
    commit_slot_cls u_cls (
      .vld  (head_vld[g]),
      .head (heads[g]),
      .cls  (cls[g])
    );
  end

  commit_scan #(.W(W), .LOOK(LOOK), .ISZ(ISZ)) u_scan (
    .enable         (enable),
    .stores_pending (stores_pending),
    .cls            (cls),
    .heads          (heads),
    .pop            (head_pop),
    .ncommit        (ncommit),
    .nsq            (nsq),
    .ninst          (ninst),
    .done_vld       (done_vld),
    .done_seq       (done_seq),
    .nspec          (nspec_req),
    .unc            (uncached_req),
    .trap           (trap_req),
    .bad            (bad),
    .req_seq        (req_seq),
    .pc_upd         (pc_upd),
    .pc_new         (pc_new),
    .npc_new        (npc_new)
  );

  assign done_tid = grant_tid;
  assign trap_tid = grant_tid;

  commit_thread_ctx #(.NT(NT), .TIDW(TIDW)) u_ctx (
    .clk        (clk),
    .rst_n      (rst_n),
    .upd        (pc_upd),
    .upd_tid    (grant_tid),
    .pc_new     (pc_new),
    .npc_new    (npc_new),
    .trap_set   (trap_req),
    .trap_clear (trap_clear),
    .pc_flat    (thread_pc),
    .npc_flat   (thread_npc),
    .pend       (trap_pending)
  );

  commit_stats #(.W(W), .LOOK(LOOK), .DEPTH(DEPTH), .SW(SW), .TIDW(TIDW)) u_stats (
    .clk         (clk),
    .rst_n       (rst_n),
    .pop         (head_pop),
    .ncommit     (ncommit),
    .nsq         (nsq),
    .ninst       (ninst),
    .bad         (bad),
    .tid         (grant_tid),
    .rob_used    (rob_used),
    .err_unknown (err_unknown),
    .fb_vld      (fb_vld),
    .fb_tid      (fb_tid),
    .fb_free     (fb_free),
    .fb_empty    (fb_empty),
    .stat_last   (stat_last),
    .stat_full   (stat_full),
    .stat_sq     (stat_sq),
    .stat_inst   (stat_inst)
  );
endmodule

// File: rtl/commit_ctrl_chk.sv
module commit_ctrl_chk #(
  parameter int NT   = 2,
  parameter int W    = 2,
  parameter int LOOK = 4,
  parameter int TIDW = 1,
  parameter int CW   = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            grant_vld,
  input logic [TIDW-1:0] grant_tid,
  input logic [LOOK-1:0] head_vld,
  input logic [LOOK-1:0] head_pop,
  input logic            stores_pending,
  input logic            done_vld,
  input logic            nspec_req,
  input logic            uncached_req,
  input logic            trap_req,
  input logic [TIDW-1:0] trap_tid,
  input logic [NT-1:0]   trap_pending,
  input logic            err_unknown,
  input logic            fb_vld,
  input logic [CW-1:0]   stat_last
);
  AST_POP_OFFERED: assert property (@(posedge clk) disable iff (!rst_n)
    (head_pop & ~head_vld) == '0); // R1
  AST_POP_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
    ((head_pop + LOOK'(1)) & head_pop) == '0); // R1
  AST_WIDTH_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    stat_last <= CW'(W)); // R1
  AST_BLOCKED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant_vld || trap_pending[grant_tid]) |-> (head_pop == '0 && !done_vld && !trap_req)); // R2
  AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({nspec_req, uncached_req, trap_req})); // R4
  AST_NSPEC_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
    nspec_req |-> !stores_pending); // R4
  AST_TRAP_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> !stores_pending); // R6
  AST_TRAP_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |=> trap_pending[$past(trap_tid)]); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_unknown |=> err_unknown); // R12
  AST_FB_AFTER_POP: assert property (@(posedge clk) disable iff (!rst_n)
    fb_vld |-> $past(head_pop != '0)); // R11
endmodule

bind commit_ctrl commit_ctrl_chk #(.NT(NT), .W(W), .LOOK(LOOK), .TIDW(TIDW), .CW(CW)) u_chk (.*);

// File: tb/test_commit_ctrl.sv
module test_commit_ctrl;
  import commit_pkg::*;
  localparam int NT = 2, W = 2, LOOK = 4, DEPTH = 16, ISZ = 4, SW = 16;
  localparam int TIDW = 1, HW = HEAD_W, CW = 3, UW = 5;

  logic               clk = 1'b0, rst_n = 1'b0;
  logic               grant_vld = 1'b0;
  logic [TIDW-1:0]    grant_tid = '0;
  logic [LOOK-1:0]    head_vld = '0;
  logic [LOOK*HW-1:0] head_bus = '0;
  logic [LOOK-1:0]    head_pop;
  logic               stores_pending = 1'b0;
  logic [UW-1:0]      rob_used = UW'(8);
  logic [NT-1:0]      trap_clear = '0;
  logic               done_vld, nspec_req, uncached_req, trap_req, err_unknown;
  logic [TIDW-1:0]    done_tid, trap_tid, fb_tid;
  logic [SEQ_W-1:0]   done_seq, req_seq;
  logic [NT-1:0]      trap_pending;
  logic [NT*PC_W-1:0] thread_pc, thread_npc;
  logic               fb_vld, fb_empty;
  logic [UW-1:0]      fb_free;
  logic [CW-1:0]      stat_last;
  logic [SW-1:0]      stat_full, stat_sq, stat_inst;

  int total = 0, bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  commit_ctrl #(.NT(NT), .W(W), .LOOK(LOOK), .DEPTH(DEPTH), .ISZ(ISZ), .SW(SW)) i_commit_ctrl (.*);

  // kinds: 0 absent, 1 ok, 2 squashed, 3 not ready, 4 serializing unexecuted,
  // 5 unexecuted load, 6 fault, 7 nop, 8 unknown unexecuted
  function automatic head_t mk(input logic [3:0] k, input logic [SEQ_W-1:0] s);
    head_t h;
    h          = '0;
    h.ready    = (k != 4'd3);
    h.executed = !(k == 4'd4 || k == 4'd5 || k == 4'd8);
    h.squashed = (k == 4'd2);
    h.membar   = (k == 4'd4);
    h.load     = (k == 4'd5);
    h.fault    = (k == 4'd6);
    h.nop      = (k == 4'd7);
    h.seq      = s;
    h.pc       = 32'h1000 + 32'(s) * 4;
    h.npc      = h.pc + 32'd8;
    return h;
  endfunction

  task automatic drive(input logic g, input logic [TIDW-1:0] t, input logic st,
                       input logic [15:0] kinds, input logic [SEQ_W-1:0] base);
    grant_vld      = g;
    grant_tid      = t;
    stores_pending = st;
    for (int i = 0; i < LOOK; i++) begin
      head_vld[i]             = (kinds[i*4 +: 4] != 4'd0);
      head_bus[i*HW +: HW]    = mk(kinds[i*4 +: 4], base + SEQ_W'(i));
    end
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    #1;
  endtask

  // {stores, kinds[15:0] (slot3..slot0), pop[3:0], {nspec, uncached, trap}}
  localparam logic [23:0] TBL [12] = '{
    {1'b0, 16'h1111, 4'b0011, 3'b000},
    {1'b0, 16'h1212, 4'b1111, 3'b000},
    {1'b0, 16'h1131, 4'b0001, 3'b000},
    {1'b0, 16'h1114, 4'b0000, 3'b100},
    {1'b1, 16'h1114, 4'b0000, 3'b000},
    {1'b0, 16'h1141, 4'b0001, 3'b000},
    {1'b0, 16'h1142, 4'b0001, 3'b100},
    {1'b1, 16'h1115, 4'b0000, 3'b010},
    {1'b0, 16'h1151, 4'b0001, 3'b010},
    {1'b0, 16'h1110, 4'b0000, 3'b000},
    {1'b0, 16'h1177, 4'b0011, 3'b000},
    {1'b0, 16'h2222, 4'b1111, 3'b000}
  };

  initial begin
    #(200000 * 10);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] ins0;
    #22 rst_n = 1'b1;
    step();
    chk("R6 reset trap_pending", 64'(trap_pending), 0);
    chk("R12 reset err", 64'(err_unknown), 0);
    chk("R11 reset fb_vld", 64'(fb_vld), 0);
    chk("R10 reset stat_full", 64'(stat_full), 0);
    chk("R8 reset pc", 64'(thread_pc), 0);

    for (int v = 0; v < 12; v++) begin
      logic [15:0] kinds;
      logic [3:0]  epop;
      int          ncom;
      logic        edv;
      logic [SEQ_W-1:0] eseq, base;
      kinds = TBL[v][22:7];
      epop  = TBL[v][6:3];
      base  = SEQ_W'(v * 8);
      ncom  = 0; edv = 1'b0; eseq = '0;
      for (int i = 0; i < LOOK; i++)
        if (epop[i] && (kinds[i*4 +: 4] == 4'd1 || kinds[i*4 +: 4] == 4'd7)) begin
          ncom++; edv = 1'b1; eseq = base + SEQ_W'(i);
        end
      drive(1'b1, 1'b0, TBL[v][23], kinds, base);
      #4;
      chk("R1 pop mask", 64'(head_pop), 64'(epop));
      chk("R4 nspec_req", 64'(nspec_req), 64'(TBL[v][2]));
      chk("R5 uncached_req", 64'(uncached_req), 64'(TBL[v][1]));
      chk("R6 trap_req", 64'(trap_req), 0);
      chk("R7 done_vld", 64'(done_vld), 64'(edv));
      if (edv) chk("R7 done_seq", 64'(done_seq), 64'(eseq));
      if (TBL[v][2] || TBL[v][1]) begin
        logic [SEQ_W-1:0] rs;
        rs = base;
        for (int i = LOOK - 1; i >= 0; i--) if (!epop[i]) rs = base + SEQ_W'(i);
        chk("R4 req_seq", 64'(req_seq), 64'(rs));
      end
      step();
      chk("R10 stat_last", 64'(stat_last), 64'(ncom));
    end
    drive(1'b0, 1'b0, 1'b0, 16'h0000, 0);
    step();
    chk("R10 stat_full", 64'(stat_full), 3);
    chk("R3 stat_sq", 64'(stat_sq), 7);
    chk("R9 stat_inst", 64'(stat_inst), 7);

    // free-entry broadcast and PC update, thread 1
    rob_used = UW'(5);
    drive(1'b1, 1'b1, 1'b0, 16'h0001, 100);
    step();
    chk("R11 fb_vld", 64'(fb_vld), 1);
    chk("R11 fb_tid", 64'(fb_tid), 1);
    chk("R11 fb_free", 64'(fb_free), 12);
    chk("R11 fb_empty", 64'(fb_empty), 0);
    chk("R8 pc after commit", 64'(thread_pc[PC_W +: PC_W]), 64'h1198);
    chk("R8 npc after commit", 64'(thread_npc[PC_W +: PC_W]), 64'h119C);
    rob_used = UW'(2);
    drive(1'b1, 1'b1, 1'b0, 16'h0011, 200);
    step();
    chk("R11 fb_free drained", 64'(fb_free), 16);
    chk("R11 fb_empty drained", 64'(fb_empty), 1);
    rob_used = UW'(8);
    drive(1'b0, 1'b0, 1'b0, 16'h0000, 0);
    step();
    chk("R11 fb_vld idle", 64'(fb_vld), 0);

    // faults on thread 0
    drive(1'b1, 1'b0, 1'b1, 16'h0006, 300);
    #4;
    chk("R6 fault waits on stores", 64'(trap_req), 0);
    step();
    chk("R8 pc at stalled head", 64'(thread_pc[0 +: PC_W]), 64'h14B0);
    chk("R8 npc at stalled head", 64'(thread_npc[0 +: PC_W]), 64'h14B8);
    chk("R6 no pending yet", 64'(trap_pending), 0);
    drive(1'b1, 1'b0, 1'b0, 16'h0061, 310);
    #4;
    chk("R6 fault not first", 64'(trap_req), 0);
    chk("R6 pop before fault", 64'(head_pop), 1);
    step();
    drive(1'b1, 1'b0, 1'b0, 16'h0006, 320);
    #4;
    chk("R6 trap_req", 64'(trap_req), 1);
    chk("R6 trap_tid", 64'(trap_tid), 0);
    step();
    chk("R6 trap_pending set", 64'(trap_pending), 1);
    drive(1'b1, 1'b0, 1'b0, 16'h0011, 330);
    #4;
    chk("R2 parked thread pops", 64'(head_pop), 0);
    chk("R2 parked thread done", 64'(done_vld), 0);
    drive(1'b0, 1'b1, 1'b0, 16'h0011, 340);
    #4;
    chk("R2 no grant pops", 64'(head_pop), 0);
    trap_clear = 2'b01;
    step();
    trap_clear = '0;
    chk("R6 trap cleared", 64'(trap_pending), 0);

    // nop accounting
    ins0 = stat_inst;
    drive(1'b1, 1'b0, 1'b0, 16'h0017, 400);
    #4;
    chk("R9 nop counts to width", 64'(head_pop), 64'b0011);
    step();
    chk("R9 nop not architectural", 64'(stat_inst), 64'(ins0 + 16'd1));

    // unknown un-executed entry
    drive(1'b1, 1'b0, 1'b0, 16'h0008, 500);
    #4;
    chk("R12 unknown stops", 64'(head_pop), 0);
    step();
    drive(1'b0, 1'b0, 1'b0, 16'h0000, 0);
    chk("R12 err set", 64'(err_unknown), 1);
    step();
    chk("R12 err sticky", 64'(err_unknown), 1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule